// File: doc/BRIEF.md
# Split Wake-up and Select Scheduler

This block is an out-of-order instruction scheduler. Wake-up and selection sit in two separate pipeline stages, so the select logic is not on the wake-up loop. Each entry holds one instruction with two source tags and one destination tag. An operand becomes ready when its tag is seen on a broadcast. An entry whose operands are both ready is woken. In the next cycle the entry is a select candidate and broadcasts its destination tag at once, as if it had already issued. This lets a dependent be woken in time to issue in the cycle straight after its producer.

Only a limited number of candidates are granted per cycle, oldest first. A candidate that loses selection drops back to waiting. Its speculative broadcast is cancelled one cycle later. Every operand that was woken by that broadcast has its ready bit cleared and must wake again, and the same applies further down a dependence chain. To trace a cancellation, each operand records whether its ready bit came from a speculative broadcast and which entry sent it. An entry leaves the scheduler only when it is granted.

Instructions enter through a one-per-cycle allocation port. Non-speculative results, for example from long-latency units, enter through a single external tag broadcast port. Grants leave as a packed list of destination tags.

Top module: `sched_split_ws`

## Requirements
- R1: In the first cycle after reset, `alloc_ready` is 1 and `grant_valid` is all zero.
- R2: While `alloc_ready` is 0 (every entry occupied), an allocation request is ignored. That instruction is never granted later, and `alloc_ready` returns to 1 once a grant frees an entry.
- R3: An operand is ready when it is allocated ready, or when its tag matches the external broadcast or a speculative broadcast in any cycle after allocation, including the allocation cycle. An entry is granted only when both operands are ready. An instruction allocated with both operands ready in cycle A is granted in cycle A+2. An instruction whose last operand arrives on the external broadcast in cycle X is granted in cycle X+1.
- R4: A select candidate broadcasts its destination tag in its select cycle. A dependent woken by that broadcast is granted in the next cycle when the producer was granted (back-to-back issue).
- R5: At most GRANT_W (default 4) entries are granted per cycle, oldest allocation first. Slot k of the output is `grant_valid[k]` and `grant_dst[k*TAG_W +: TAG_W]`. Slot 0 holds the oldest grant, the used slots are contiguous from bit 0, and unused slots read zero.
- R6: A candidate not granted in cycle S is not a candidate in S+1. Its broadcast is cancelled in S+1, and if its operands are still ready it is granted no earlier than S+2.
- R7: An operand woken by a broadcast that is then cancelled loses its ready bit. Its entry is not granted in the cancellation cycle and must wake again, through any depth of dependence.
- R8: An entry leaves the scheduler only when granted, and each allocated instruction is granted exactly once.
- R9: Reset removes all entries and pending cancellations. A broadcast after reset of a tag that pre-reset entries waited on produces no grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc_valid | input | 1 | Allocation request this cycle |
| alloc_dst | input | TAG_W | Destination tag of the new instruction |
| alloc_src0 | input | TAG_W | First source tag |
| alloc_src0_rdy | input | 1 | First source already available |
| alloc_src1 | input | TAG_W | Second source tag |
| alloc_src1_rdy | input | 1 | Second source already available |
| alloc_ready | output | 1 | At least one free entry |
| ext_valid | input | 1 | Non-speculative tag broadcast valid |
| ext_tag | input | TAG_W | Non-speculative broadcast tag |
| grant_valid | output | GRANT_W | Granted slots, oldest in bit 0 |
| grant_dst | output | GRANT_W*TAG_W | Destination tags of the granted slots |

## Verification
The hardest situation to reach is a cancellation that propagates two levels down a dependence chain. It needs a loser of selection with a child woken by the loser's speculative tag, and a grandchild woken by the child's own speculative tag, all in consecutive cycles. The stimulus parks six instructions on one external tag, plus a child of the youngest and a grandchild of that child. One external pulse then wakes all six together, so the two youngest lose selection. The bench then checks the cycle-exact replay pattern of 4, 0, 2, 1 and 1 grants.

// File: rtl/sched_pkg.sv
// Package: default sizing shared by the scheduler and its checker.
// Assumes: tags are unique among in-flight producers (renamed registers).
package sched_pkg;
    localparam int SCHED_ENTRIES = 8;   // scheduler entries
    localparam int SCHED_TAG_W   = 5;   // tag width
    localparam int SCHED_GRANT_W = 4;   // grants per cycle
    localparam int SCHED_NSRC    = 2;   // source operands per entry
endpackage

// File: rtl/sched_wake_match.sv
// Module: compares one source tag against the external broadcast and every
// speculative broadcast of the cycle. It reports a hit, whether the hit is only
// speculative, and which entry sent the speculative tag.
// Assumes: at most one producer per tag. A non-speculative hit takes priority.
module sched_wake_match #(
    parameter int N_ENT = 8,
    parameter int TAG_W = 5,
    localparam int IDW  = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
    input  logic [TAG_W-1:0]       src_tag,
    input  logic                   ext_valid,
    input  logic [TAG_W-1:0]       ext_tag,
    input  logic [N_ENT-1:0]       spec_valid,
    input  logic [N_ENT*TAG_W-1:0] spec_tag,
    output logic                   hit,
    output logic                   hit_spec,
    output logic [IDW-1:0]         hit_id
);
    logic ext_hit;
    logic spec_any;

    // Tag comparison, lowest matching speculative sender wins.
    always_comb begin
        ext_hit  = ext_valid && (ext_tag == src_tag);
        spec_any = 1'b0;
        hit_id   = '0;
        for (int j = N_ENT - 1; j >= 0; j--) begin
            if (spec_valid[j] && (spec_tag[j*TAG_W +: TAG_W] == src_tag)) begin
                spec_any = 1'b1;
                hit_id   = IDW'(j);
            end
        end
        hit      = ext_hit || spec_any;
        hit_spec = !ext_hit && spec_any;
    end
endmodule

// File: rtl/sched_age_select.sv
// Module: oldest-first grant of up to GRANT_W eligible entries, and packing of
// their destination tags into output slots in age order.
// Assumes: older_flat[i*N_ENT+j] = 1 means entry j is older than entry i, and
// the relation is a total order over valid entries.
module sched_age_select #(
    parameter int N_ENT   = 8,
    parameter int GRANT_W = 4,
    parameter int TAG_W   = 5
) (
    input  logic [N_ENT-1:0]         eligible,
    input  logic [N_ENT*N_ENT-1:0]   older_flat,
    input  logic [N_ENT*TAG_W-1:0]   dst_flat,
    output logic [N_ENT-1:0]         grant_vec,
    output logic [GRANT_W-1:0]       grant_valid,
    output logic [GRANT_W*TAG_W-1:0] grant_dst
);
    localparam int RANK_W = $clog2(N_ENT + 1);

    // Rank each eligible entry by the count of older eligible ones, then place it.
    always_comb begin
        logic [RANK_W-1:0] rank;
        grant_vec   = '0;
        grant_valid = '0;
        grant_dst   = '0;
        for (int i = 0; i < N_ENT; i++) begin
            rank = '0;
            for (int j = 0; j < N_ENT; j++) begin
                if (eligible[j] && older_flat[i*N_ENT + j]) rank = rank + RANK_W'(1);
            end
            if (eligible[i] && (int'(rank) < GRANT_W)) begin
                grant_vec[i] = 1'b1;
                for (int k = 0; k < GRANT_W; k++) begin
                    if (int'(rank) == k) begin
                        grant_valid[k]                = 1'b1;
                        grant_dst[k*TAG_W +: TAG_W] = dst_flat[i*TAG_W +: TAG_W];
                    end
                end
            end
        end
    end
endmodule

// File: rtl/sched_split_ws.sv
// Module: scheduler with wake-up and select in separate stages. A woken entry
// becomes a candidate next cycle and broadcasts its destination tag as if
// issued. Candidates that are not granted are cancelled one cycle later, and
// every operand woken by a cancelled broadcast loses its ready bit.
// Assumes: unique in-flight tags, one allocation and one external broadcast
// per cycle. Synchronous active-low reset.
module sched_split_ws
    import sched_pkg::*;
#(
    parameter int N_ENT   = SCHED_ENTRIES,
    parameter int TAG_W   = SCHED_TAG_W,
    parameter int GRANT_W = SCHED_GRANT_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     alloc_valid,
    input  logic [TAG_W-1:0]         alloc_dst,
    input  logic [TAG_W-1:0]         alloc_src0,
    input  logic                     alloc_src0_rdy,
    input  logic [TAG_W-1:0]         alloc_src1,
    input  logic                     alloc_src1_rdy,
    output logic                     alloc_ready,
    input  logic                     ext_valid,
    input  logic [TAG_W-1:0]         ext_tag,
    output logic [GRANT_W-1:0]       grant_valid,
    output logic [GRANT_W*TAG_W-1:0] grant_dst
);
    localparam int IDW  = (N_ENT > 1) ? $clog2(N_ENT) : 1;
    localparam int NSRC = SCHED_NSRC;

    logic [N_ENT-1:0]       valid_q, cand_q, cancel_q, kill_any, eligible, grant_vec;
    logic [N_ENT-1:0]       alloc_oh;
    logic                   alloc_go;
    logic [N_ENT*TAG_W-1:0] dst_flat;
    logic [N_ENT*N_ENT-1:0] older_flat;

    logic [TAG_W-1:0] a_tag [NSRC];
    logic [NSRC-1:0]  a_rdy, a_hit, a_hsp;
    logic [IDW-1:0]   a_hid [NSRC];

    // Lowest free entry receives the next allocation.
    always_comb begin
        alloc_oh = '0;
        for (int i = N_ENT - 1; i >= 0; i--) begin
            if (!valid_q[i]) begin
                alloc_oh    = '0;
                alloc_oh[i] = 1'b1;
            end
        end
    end

    assign alloc_ready = ~&valid_q;
    assign alloc_go    = alloc_valid && alloc_ready;
    assign eligible    = cand_q & ~kill_any;

    // Incoming operands snoop this cycle's broadcasts too.
    for (genvar gk = 0; gk < NSRC; gk++) begin : g_asrc
        assign a_tag[gk] = (gk == 0) ? alloc_src0 : alloc_src1;
        assign a_rdy[gk] = (gk == 0) ? alloc_src0_rdy : alloc_src1_rdy;
        sched_wake_match #(.N_ENT(N_ENT), .TAG_W(TAG_W)) u_amatch (
            .src_tag(a_tag[gk]), .ext_valid(ext_valid), .ext_tag(ext_tag),
            .spec_valid(cand_q), .spec_tag(dst_flat),
            .hit(a_hit[gk]), .hit_spec(a_hsp[gk]), .hit_id(a_hid[gk]));
    end

    for (genvar gi = 0; gi < N_ENT; gi++) begin : g_ent
        logic             v_q, c_q;
        logic [TAG_W-1:0] d_q;
        logic [N_ENT-1:0] o_q;
        logic [NSRC-1:0]  kill, rdy_nv;
        logic             here, wake;

        assign here       = alloc_go && alloc_oh[gi];
        assign kill_any[gi] = |kill;
        assign wake       = v_q && !c_q && (&rdy_nv);
        assign valid_q[gi] = v_q;
        assign cand_q[gi]  = c_q;
        assign dst_flat[gi*TAG_W +: TAG_W]   = d_q;
        assign older_flat[gi*N_ENT +: N_ENT] = o_q;

        for (genvar gk = 0; gk < NSRC; gk++) begin : g_op
            logic             r_q, s_q, hit, hsp, keep;
            logic [IDW-1:0]   w_q, hid;
            logic [TAG_W-1:0] t_q;

            sched_wake_match #(.N_ENT(N_ENT), .TAG_W(TAG_W)) u_match (
                .src_tag(t_q), .ext_valid(ext_valid), .ext_tag(ext_tag),
                .spec_valid(cand_q), .spec_tag(dst_flat),
                .hit(hit), .hit_spec(hsp), .hit_id(hid));

            assign kill[gk]   = v_q && r_q && s_q && cancel_q[w_q];
            assign keep       = r_q && !kill[gk];
            assign rdy_nv[gk] = keep || hit;

            // Operand state: capture at allocation, then wake, confirm or cancel.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    r_q <= 1'b0;
                    s_q <= 1'b0;
                    w_q <= '0;
                    t_q <= '0;
                end else if (here) begin
                    t_q <= a_tag[gk];
                    r_q <= a_rdy[gk] || a_hit[gk];
                    s_q <= !a_rdy[gk] && a_hit[gk] && a_hsp[gk];
                    w_q <= a_hid[gk];
                end else begin
                    r_q <= keep || hit;
                    s_q <= !keep && hit && hsp;
                    if (!keep) w_q <= hid;
                end
            end
        end

        // Entry state: occupancy, candidate stage and age row.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                v_q <= 1'b0;
                c_q <= 1'b0;
                d_q <= '0;
                o_q <= '0;
            end else if (here) begin
                v_q <= 1'b1;
                c_q <= 1'b0;
                d_q <= alloc_dst;
                o_q <= valid_q & ~grant_vec;
            end else begin
                v_q <= v_q && !grant_vec[gi];
                c_q <= wake;
                if (alloc_go) o_q <= o_q & ~alloc_oh;
            end
        end
    end

    // Losing candidates have their broadcast cancelled in the next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) cancel_q <= '0;
        else        cancel_q <= cand_q & ~grant_vec;
    end

    sched_age_select #(.N_ENT(N_ENT), .GRANT_W(GRANT_W), .TAG_W(TAG_W)) u_select (
        .eligible(eligible), .older_flat(older_flat), .dst_flat(dst_flat),
        .grant_vec(grant_vec), .grant_valid(grant_valid), .grant_dst(grant_dst));
endmodule

// File: rtl/sched_split_ws_chk.sv
// Module: property checker for sched_split_ws, attached by bind below.
// Assumes: observes internal entry vectors through the bind connections.
module sched_split_ws_chk #(
    parameter int N_ENT   = 8,
    parameter int GRANT_W = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               alloc_valid,
    input logic               alloc_ready,
    input logic [GRANT_W-1:0] grant_valid,
    input logic [N_ENT-1:0]   valid_q,
    input logic [N_ENT-1:0]   cand_q,
    input logic [N_ENT-1:0]   grant_vec,
    input logic [N_ENT-1:0]   kill_any
);
    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (alloc_ready && (grant_valid == '0)));

    assert_full_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_valid && !alloc_ready) |=> ($countones(valid_q) <= $past($countones(valid_q))));

    assert_grant_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(grant_vec) == $countones(grant_valid));

    for (genvar gi = 0; gi < N_ENT; gi++) begin : g_e
        assert_grant_is_cand_R5: assert property (@(posedge clk) disable iff (!rst_n)
            grant_vec[gi] |-> cand_q[gi]);

        assert_loser_leaves_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (cand_q[gi] && !grant_vec[gi]) |=> !cand_q[gi]);

        assert_kill_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
            kill_any[gi] |-> !grant_vec[gi]);

        assert_grant_frees_R8: assert property (@(posedge clk) disable iff (!rst_n)
            grant_vec[gi] |=> !valid_q[gi]);
    end
endmodule

bind sched_split_ws sched_split_ws_chk #(.N_ENT(N_ENT), .GRANT_W(GRANT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_ready(alloc_ready),
    .grant_valid(grant_valid), .valid_q(valid_q), .cand_q(cand_q),
    .grant_vec(grant_vec), .kill_any(kill_any));

// File: tb/test_sched_split_ws.sv
// Bench: directed scenarios, one task each. Inputs change 1 ns after a rising
// edge and outputs are sampled at the falling edge.
module test_sched_split_ws;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int NE = 8;
    localparam int TW = 5;
    localparam int GW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic alloc_valid, alloc_src0_rdy, alloc_src1_rdy, alloc_ready, ext_valid;
    logic [TW-1:0] alloc_dst, alloc_src0, alloc_src1, ext_tag;
    logic [GW-1:0] grant_valid;
    logic [GW*TW-1:0] grant_dst;

    int n_tests = 0;
    int n_fail  = 0;

    sched_split_ws #(.N_ENT(NE), .TAG_W(TW), .GRANT_W(GW)) i_sched_split_ws (
        .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_dst(alloc_dst),
        .alloc_src0(alloc_src0), .alloc_src0_rdy(alloc_src0_rdy),
        .alloc_src1(alloc_src1), .alloc_src1_rdy(alloc_src1_rdy),
        .alloc_ready(alloc_ready), .ext_valid(ext_valid), .ext_tag(ext_tag),
        .grant_valid(grant_valid), .grant_dst(grant_dst));

    always #2.5 clk = ~clk;

    function automatic logic [GW*TW-1:0] tg(input int a, input int b, input int c, input int d);
        return {TW'(d), TW'(c), TW'(b), TW'(a)};
    endfunction

    task automatic clear_in();
        alloc_valid = 1'b0; alloc_dst = '0; alloc_src0 = '0; alloc_src1 = '0;
        alloc_src0_rdy = 1'b0; alloc_src1_rdy = 1'b0; ext_valid = 1'b0; ext_tag = '0;
    endtask

    task automatic put(input int dst, input int s0, input bit r0, input int s1, input bit r1);
        alloc_valid = 1'b1; alloc_dst = TW'(dst);
        alloc_src0 = TW'(s0); alloc_src0_rdy = r0;
        alloc_src1 = TW'(s1); alloc_src1_rdy = r1;
    endtask

    task automatic ext(input int t);
        ext_valid = 1'b1; ext_tag = TW'(t);
    endtask

    // One cycle: sample grants at the falling edge, then advance past the rising edge.
    task automatic step_check(input int n, input logic [GW*TW-1:0] exp_d, input string req);
        logic [GW-1:0] egv;
        egv = GW'((1 << n) - 1);
        @(negedge clk);
        n_tests++;
        if (grant_valid !== egv || grant_dst !== exp_d) begin
            n_fail++;
            $display("FAIL %s: grant_valid=%b grant_dst=%h expected %b %h",
                     req, grant_valid, grant_dst, egv, exp_d);
        end
        @(posedge clk);
        #1;
        clear_in();
    endtask

    task automatic check_ready(input logic exp, input string req);
        n_tests++;
        if (alloc_ready !== exp) begin
            n_fail++;
            $display("FAIL %s: alloc_ready=%b expected %b", req, alloc_ready, exp);
        end
    endtask

    task automatic t_reset_state();
        check_ready(1'b1, "R1 reset ready");
        step_check(0, '0, "R1 reset no grant");
    endtask

    task automatic t_single();
        put(1, 0, 1, 0, 1);
        step_check(0, '0, "R3 alloc cycle");
        step_check(0, '0, "R3 wake cycle");
        step_check(1, tg(1, 0, 0, 0), "R3 grant at A+2");
        step_check(0, '0, "R8 granted once");
    endtask

    task automatic t_chain();
        put(2, 0, 1, 0, 1);
        step_check(0, '0, "R4 producer alloc");
        put(3, 2, 0, 0, 1);
        step_check(0, '0, "R4 consumer alloc");
        step_check(1, tg(2, 0, 0, 0), "R4 producer grant");
        step_check(1, tg(3, 0, 0, 0), "R4 back-to-back consumer");
        step_check(0, '0, "R8 chain drained");
    endtask

    task automatic t_two_ops();
        put(4, 9, 0, 10, 0);
        step_check(0, '0, "R3 alloc both waiting");
        step_check(0, '0, "R3 idle");
        ext(9);
        step_check(0, '0, "R3 first operand only");
        step_check(0, '0, "R3 one operand not enough");
        step_check(0, '0, "R3 still waiting");
        ext(10);
        step_check(0, '0, "R3 second operand cycle");
        step_check(1, tg(4, 0, 0, 0), "R3 grant at X+1");
        step_check(0, '0, "R8 once");
    endtask

    task automatic t_width_replay();
        for (int i = 0; i < 6; i++) begin
            put(10 + i, 3, 0, 0, 1);
            step_check(0, '0, "R5 fill");
        end
        put(16, 15, 0, 0, 1);
        step_check(0, '0, "R7 child alloc");
        put(17, 16, 0, 0, 1);
        step_check(0, '0, "R7 grandchild alloc");
        ext(3);
        step_check(0, '0, "R3 common wake");
        step_check(4, tg(10, 11, 12, 13), "R5 four oldest");
        step_check(0, '0, "R7 child blocked by cancel");
        step_check(2, tg(14, 15, 0, 0), "R6 losers reselected");
        step_check(1, tg(16, 0, 0, 0), "R7 child rewoken");
        step_check(1, tg(17, 0, 0, 0), "R7 grandchild rewoken");
        step_check(0, '0, "R8 drained");
    endtask

    task automatic t_full();
        for (int i = 0; i < NE; i++) begin
            put(20 + i, 5, 0, 0, 1);
            step_check(0, '0, "R2 fill");
        end
        check_ready(1'b0, "R2 full");
        put(30, 0, 1, 0, 1);
        step_check(0, '0, "R2 alloc while full");
        ext(5);
        step_check(0, '0, "R2 wake all");
        step_check(4, tg(20, 21, 22, 23), "R5 first group");
        step_check(0, '0, "R6 gap");
        step_check(4, tg(24, 25, 26, 27), "R6 second group");
        check_ready(1'b1, "R2 ready again");
        for (int i = 0; i < 3; i++) step_check(0, '0, "R2 ignored never granted");
    endtask

    task automatic t_reset_clear();
        put(7, 6, 0, 0, 1);
        step_check(0, '0, "R9 alloc");
        put(8, 6, 0, 0, 1);
        step_check(0, '0, "R9 alloc");
        rst_n = 1'b0;
        step_check(0, '0, "R9 in reset");
        rst_n = 1'b1;
        check_ready(1'b1, "R9 after reset");
        ext(6);
        step_check(0, '0, "R9 broadcast");
        step_check(0, '0, "R9 no stale grant");
        step_check(0, '0, "R9 no stale grant late");
    endtask

    initial begin
        clear_in();
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        t_reset_state();
        t_single();
        t_chain();
        t_two_ops();
        t_width_replay();
        t_full();
        t_reset_clear();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule